// File: doc/BRIEF.md
# MDIO Management Transaction Controller

This block lets software reach the management registers of an external PHY through two memory-mapped words. A command word holds the transfer direction, the PHY address and the PHY register number. Writing the command word while the block is idle starts one clause-22 management frame on the MDC/MDIO pair. A data word supplies the 16-bit value for a write, and for a read it receives the value the PHY returns.

Software polls a busy flag in the command word to learn when the transfer has finished. MDC is made from the system clock by a counter. It runs only while a frame is in flight and rests low otherwise. Outgoing bits change only while MDC is low. Incoming read bits are taken at the rising edges of MDC.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command word (offset 0x14) and the data word (offset 0x18) read as zero, and MDC and the MDIO output enable are low.
- R2: A write to offset 0x14 while idle starts a frame. Readback is bit 0 busy, bit 1 direction (1 = write, 0 = read), bits 10:6 register number, bits 15:11 PHY address, and all other bits zero. Busy reads 1 for exactly 128*HALF_CYCLES clock cycles, counted from the first cycle after the write.
- R3: MDC has a low phase and then a high phase of HALF_CYCLES clock cycles each, 64 periods per frame, and stays low while idle.
- R4: Each frame carries 64 bits, most significant bit of each field first: 32 ones, start 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register number, 2 turnaround bits, then 16 data bits. MDIO output changes only while MDC is low.
- R5: On a write the turnaround is driven as 10 and the data bits come from the data word. The output enable is high for all 64 bits.
- R6: On a read the output enable is high for the first 46 bits and low during the turnaround and the data bits.
- R7: On a read, MDIO input is sampled at the rising MDC edge of each of the 16 data bits. Once busy clears, the data word holds that value in bits 15:0 with its upper bits zero.
- R8: A write to the command word while busy is ignored: the readback fields and the frame in flight are unchanged.
- R9: A write to the data word while busy is ignored: the data word keeps its value, and the data bits of a write frame are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_out | output | 1 | MDIO output value |
| mdio_in | input | 1 | MDIO value from the pad |

## Verification
Busy rises at the clock edge that takes the command write. It falls 128*HALF_CYCLES edges later, at the same edge where MDC makes its last falling transition. The read value reaches the data word at that same edge. The bench samples registers half a period after each edge and counts busy samples from the first negative edge after the write, so the count must equal 128*HALF_CYCLES exactly. Frame and enable bits are captured at MDC rising edges, which fall HALF_CYCLES cycles after the last output change. The PHY model changes MDIO input at MDC falling edges, so the design samples that input a full half period after it settles.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int CTRL_OFS   = 'h14;
    localparam int DATA_OFS   = 'h18;
    localparam int BUSY_BIT   = 0;
    localparam int DIR_BIT    = 1;
    localparam int REG_LSB    = 6;
    localparam int PHY_LSB    = 11;
    localparam int FIELD_W    = 5;
    localparam int WORD_W     = 16;
    localparam int FRAME_BITS = 64;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        logic                  busy;
        logic                  is_wr;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] tx_sh;
        logic [WORD_W-1:0]     rx_sh;
    } eng_s;

    typedef struct packed {
        logic               is_wr;
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] regno;
        logic [WORD_W-1:0]  data;
    } regs_s;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    typedef struct packed {
        logic          mdc;
        logic [CW-1:0] cnt;
    } gen_s;

    gen_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        rise_stb = 1'b0;
        fall_stb = 1'b0;
        if (!run) begin
            st_d.mdc = 1'b0;
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
            rise_stb = ~st_q.mdc;
            fall_stb = st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc = st_q.mdc;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_wr,
    input  logic [FIELD_W-1:0] start_phy,
    input  logic [FIELD_W-1:0] start_reg,
    input  logic [WORD_W-1:0]  start_data,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               mdio_in,
    output logic               busy,
    output logic               mdio_out,
    output logic               mdio_oe,
    output logic               done,
    output logic [WORD_W-1:0]  rd_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);

    eng_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (start && !st_q.busy) begin
            st_d.busy  = 1'b1;
            st_d.is_wr = start_wr;
            st_d.idx   = '0;
            st_d.tx_sh = {32'hFFFF_FFFF, 2'b01,
                          start_wr ? 2'b01 : 2'b10,
                          start_phy, start_reg,
                          start_wr ? 2'b10 : 2'b11,
                          start_wr ? start_data : 16'hFFFF};
        end else if (st_q.busy) begin
            if (rise_stb && !st_q.is_wr && st_q.idx >= DAT_IDX)
                st_d.rx_sh = {st_q.rx_sh[WORD_W-2:0], mdio_in};
            if (fall_stb) begin
                if (st_q.idx == LAST_IDX) begin
                    st_d.busy = 1'b0;
                    done      = 1'b1;
                end else begin
                    st_d.idx   = st_q.idx + 1'b1;
                    st_d.tx_sh = {st_q.tx_sh[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign mdio_out = st_q.busy ? st_q.tx_sh[FRAME_BITS-1] : 1'b1;
    assign mdio_oe  = st_q.busy && (st_q.is_wr || st_q.idx < TA_IDX);
    assign rd_data  = st_d.rx_sh;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int HALF_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_oe,
    output logic              mdio_out,
    input  logic              mdio_in
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

    regs_s             regs_d, regs_q;
    logic              busy_w, done_w, rise_w, fall_w, start_w;
    logic              ctrl_hit, data_hit;
    logic [WORD_W-1:0] rd_w;
    logic [31:0]       ctrl_word;
    logic              unused_hi;

    assign unused_hi = ^reg_wdata[31:16];
    assign ctrl_hit  = (reg_addr == CTRL_A);
    assign data_hit  = (reg_addr == DATA_A);
    assign start_w   = reg_we && ctrl_hit && !busy_w;

    always_comb begin
        regs_d = regs_q;
        if (start_w) begin
            regs_d.is_wr = reg_wdata[DIR_BIT];
            regs_d.regno = reg_wdata[REG_LSB +: FIELD_W];
            regs_d.phy   = reg_wdata[PHY_LSB +: FIELD_W];
        end
        if (reg_we && data_hit && !busy_w)
            regs_d.data = reg_wdata[WORD_W-1:0];
        if (done_w && !regs_q.is_wr)
            regs_d.data = rd_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[BUSY_BIT]                = busy_w;
        ctrl_word[DIR_BIT]                 = regs_q.is_wr;
        ctrl_word[REG_LSB +: FIELD_W]      = regs_q.regno;
        ctrl_word[PHY_LSB +: FIELD_W]      = regs_q.phy;
    end

    always_comb begin
        reg_rdata = '0;
        if (ctrl_hit)      reg_rdata = ctrl_word;
        else if (data_hit) reg_rdata = {16'h0000, regs_q.data};
    end

    mdio_mdc_gen #(.HALF_CYCLES(HALF_CYCLES)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy_w),
        .mdc      (mdc),
        .rise_stb (rise_w),
        .fall_stb (fall_w)
    );

    mdio_frame_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_w),
        .start_wr   (reg_wdata[DIR_BIT]),
        .start_phy  (reg_wdata[PHY_LSB +: FIELD_W]),
        .start_reg  (reg_wdata[REG_LSB +: FIELD_W]),
        .start_data (regs_q.data),
        .rise_stb   (rise_w),
        .fall_stb   (fall_w),
        .mdio_in    (mdio_in),
        .busy       (busy_w),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe),
        .done       (done_w),
        .rd_data    (rd_w)
    );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk #(
    parameter int ADDR_W      = 8,
    parameter int HALF_CYCLES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mdc,
    input logic              mdio_oe,
    input logic              mdio_out,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       ctrl_word
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(mdio_mgmt_pkg::CTRL_OFS);
    localparam int unsigned FRAME_CYC = 128 * HALF_CYCLES;

    logic [31:0] busy_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt_q <= '0;
        else if (busy) busy_cnt_q <= busy_cnt_q + 1'b1;
        else           busy_cnt_q <= '0;
    end

    // R2: busy lasts exactly the frame length
    a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_cnt_q == FRAME_CYC);

    // R3: MDC rests low when idle
    a_r3_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R4: output held through the MDC high phase
    a_r4_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_out));

    // R5: a write frame drives the line throughout
    a_r5_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_word[1]) |-> mdio_oe);

    // R6: the line is driven only inside a frame
    a_r6_oe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);

    // R8: command fields hold against writes while busy
    a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == CTRL_A) |=> $stable(ctrl_word[15:1]));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(
    .ADDR_W      (ADDR_W),
    .HALF_CYCLES (HALF_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_w),
    .mdc       (mdc),
    .mdio_oe   (mdio_oe),
    .mdio_out  (mdio_out),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .ctrl_word (ctrl_word)
);

// File: tb/mdio_mgmt_ctrl_test.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int ADDR_W     = 8;
    localparam logic [ADDR_W-1:0] CTRL_A = 8'h14;
    localparam logic [ADDR_W-1:0] DATA_A = 8'h18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_we = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              mdc, mdio_oe, mdio_out;
    logic              mdio_in = 1'b1;

    int checks = 0;
    int fails  = 0;

    mdio_mgmt_ctrl #(.ADDR_W(ADDR_W), .HALF_CYCLES(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_oe(mdio_oe), .mdio_out(mdio_out), .mdio_in(mdio_in)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    // PHY model: capture at MDC rise, answer at MDC fall
    logic [63:0] cap = '0;
    logic [63:0] oe_cap = '0;
    logic [15:0] resp = '0;
    int rises = 0;
    int cyc = 0;
    int last_rise = 0;
    int rise_gap = 0;

    always @(negedge clk) cyc = cyc + 1;

    always @(posedge mdc) begin
        cap       = {cap[62:0], mdio_out};
        oe_cap    = {oe_cap[62:0], mdio_oe};
        rises     = rises + 1;
        rise_gap  = cyc - last_rise;
        last_rise = cyc;
    end

    always @(negedge mdc) begin
        int idx;
        idx = rises % 64;
        if (idx >= 48)      mdio_in = resp[63 - idx];
        else if (idx == 47) mdio_in = 1'b0;
        else                mdio_in = 1'b1;
    end

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] cmd(input bit wr, input logic [4:0] phy,
                                        input logic [4:0] rg);
        return {16'h0, phy, rg, 4'b0, wr, 1'b0};
    endfunction

    task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wdat, input logic [15:0] rsp,
                           input bit poke);
        logic [31:0] rd, d0;
        logic [63:0] exp;
        time t0;
        int  iter, n;
        resp = rsp;
        if (wr) bus_write(DATA_A, {16'h0, wdat});
        bus_read(DATA_A, d0);
        bus_write(CTRL_A, cmd(wr, phy, rg));
        t0 = $time;
        bus_read(CTRL_A, rd);
        check(rd == (cmd(wr, phy, rg) | 32'h1), "R2 ctrl readback", rd, cmd(wr, phy, rg) | 32'h1);
        iter = 0;
        while (rd[0] && iter < 5000) begin
            if (poke && iter == 10) begin
                bus_write(CTRL_A, cmd(!wr, ~phy, ~rg));
                bus_write(DATA_A, 32'h0000_DEAD);
                bus_read(CTRL_A, rd);
                check(rd == (cmd(wr, phy, rg) | 32'h1), "R8 cmd write ignored", rd, cmd(wr, phy, rg) | 32'h1);
                bus_read(DATA_A, rd);
                check(rd == d0, "R9 data write ignored", rd, d0);
            end
            @(negedge clk);
            bus_read(CTRL_A, rd);
            iter++;
        end
        n = int'(($time - t0 - 1) / CLK_PERIOD);
        check(n == 128 * HALF, "R2 busy length", n, 128 * HALF);
        check(rd == cmd(wr, phy, rg), "R8 ctrl after frame", rd, cmd(wr, phy, rg));
        check(!mdc && !mdio_oe, "R3 idle after frame", {mdc, mdio_oe}, 0);
        check(rise_gap == 2 * HALF, "R3 mdc period", rise_gap, 2 * HALF);
        exp = {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rg, 2'b10, wdat};
        if (wr) begin
            check(cap == exp, "R5 write frame bits", cap, exp);
            check(oe_cap == '1, "R5 write enable", oe_cap, 64'hFFFF_FFFF_FFFF_FFFF);
            bus_read(DATA_A, rd);
            check(rd == {16'h0, wdat}, "R9 data word kept", rd, {16'h0, wdat});
        end else begin
            check(cap[63:18] == exp[63:18], "R4 read header bits", cap[63:18], exp[63:18]);
            check(oe_cap == {{46{1'b1}}, 18'h0}, "R6 read enable", oe_cap, {{46{1'b1}}, 18'h0});
            bus_read(DATA_A, rd);
            check(rd == {16'h0, rsp}, "R7 read data", rd, {16'h0, rsp});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        check(!mdc && !mdio_oe, "R1 pins at reset", {mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(CTRL_A, rd);
        check(rd == 0, "R1 ctrl reset", rd, 0);
        bus_read(DATA_A, rd);
        check(rd == 0, "R1 data reset", rd, 0);
        check(!mdc && !mdio_oe, "R1 idle pins", {mdc, mdio_oe}, 0);

        for (int p = 0; p < 32; p++) begin
            run_txn(1'b0, 5'(p), 5'((p * 7 + 3) % 32), 16'h0,
                    16'((p * 2053 + 16'h1234) ^ (p << 9)), 1'b0);
            run_txn(1'b1, 5'(p), 5'(31 - p), 16'((p * 16'h0841) ^ 16'hA5C3),
                    16'h0, 1'b0);
        end
        run_txn(1'b0, 5'd5, 5'd9, 16'h0, 16'h8001, 1'b1);
        run_txn(1'b1, 5'd20, 5'd3, 16'h7E18, 16'h0, 1'b1);
        run_txn(1'b0, 5'd31, 5'd31, 16'h0, 16'hFFFF, 1'b0);
        run_txn(1'b0, 5'd0, 5'd0, 16'h0, 16'h0000, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule